// File: doc/BRIEF.md
# Indirect PHY and EEPROM Access Engine

This block sits inside a network controller's register file and carries out single 16-bit word accesses to one of two targets: the management registers of an internal PHY, or a serial configuration EEPROM. The host programs a shared address register and, for writes, a low and a high data byte. It then writes a command code that picks both the target and the direction. The engine shows a busy flag for a modelled access time. When a read finishes, the word appears split across the two data byte registers. When a write finishes, the captured word is committed to the target.

The serial wire protocols are not modelled. Each target is a small internal word store with computed power-up contents, and each kind of access has its own latency in clock cycles. The PHY store holds an auto-negotiation-complete flag and a one-hot link-mode field. Writing the reset word to its control register returns the whole PHY store to its defaults. Software ends each operation by writing zero to the command register, as a real driver would.

Top module: `mgmt_access_engine`

## Requirements
- R1: After reset, busy is low and all four host registers (address, low data, high data, command) read 0x00.
- R2: A host write with hostSel 0 loads the address register, 1 the low data byte, 2 the high data byte and 3 the command register. hostRdSel uses the same encoding and reads combinationally on hostRdData.
- R3: Command 0x04 starts an EEPROM read, 0x12 an EEPROM write, 0x0C a PHY read and 0x0A a PHY write. An accepted command raises busy on the clock edge that writes it.
- R4: Busy stays high for exactly LAT_EE cycles for EEPROM accesses, LAT_PHY_RD cycles for PHY reads and LAT_PHY_WR cycles for PHY writes.
- R5: A read places word bits 7:0 in the low data register and bits 15:8 in the high data register on the edge where busy falls. While idle, the data registers change only through host writes.
- R6: A write stores the word {high byte, low byte} as it stood when the command was accepted.
- R7: A PHY access selects register addr[4:0], so the PHY-select flag 0x40 does not change the register chosen. An EEPROM access selects word addr[5:0], so bit 6 is ignored.
- R8: A command value other than the four codes leaves busy low and touches no stored word. A command written while busy neither restarts nor changes the running access.
- R9: Writing 0x00 to the command register after completion stores 0x00, reads back as 0x00 and starts nothing.
- R10: After reset, PHY register 1 reads 0x782D (bit 5, auto-negotiation complete, set). PHY register 17 reads {LINK_MODE, 12'h000}, where LINK_MODE is the one-hot code 1 = 10M half, 2 = 10M full, 4 = 100M half, 8 = 100M full. It defaults to 8.
- R11: A PHY write of 0x8000 to register 0 returns every PHY register to its reset value, so register 0 then reads 0x0000.
- R12: After reset, EEPROM word i reads {i XOR 0xA0, i} as {high byte, low byte}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostSel | input | 2 | Register selected for writing (0 addr, 1 data low, 2 data high, 3 command) |
| hostWrData | input | 8 | Host write byte |
| hostRdSel | input | 2 | Register selected for reading, same encoding |
| hostRdData | output | 8 | Read byte of the selected register |
| busy | output | 1 | High while an access is in progress |

## Verification
The hardest situation to reach is a second command arriving while an access is still running. The engine must ignore it, leaving the latency and the returned word unchanged. The stimulus preloads both data bytes with 0xFF and starts a long EEPROM read. During the busy window it writes a PHY write code. The bench then checks that busy lasted the full EEPROM latency, that the EEPROM word came back, and that the PHY register the stray write pointed at still reads zero. A second hard case is the PHY reset. The bench first dirties PHY register 17, then writes the reset word to register 0, and expects the default link mode to read back.

// File: rtl/mgmt_access_pkg.sv
package mgmt_access_pkg;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_LO   = 2'd1;
  localparam logic [1:0] SEL_HI   = 2'd2;
  localparam logic [1:0] SEL_CMD  = 2'd3;

  localparam logic [7:0] CMD_EE_RD  = 8'h04;
  localparam logic [7:0] CMD_EE_WR  = 8'h12;
  localparam logic [7:0] CMD_PHY_RD = 8'h0C;
  localparam logic [7:0] CMD_PHY_WR = 8'h0A;

  localparam logic [15:0] PHY_RESET_WORD = 16'h8000;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // command accepted: latch address and data
    logic finish;   // access ends this cycle
    logic toPhy;    // target is the PHY store
    logic isWrite;  // direction
  } mgmtStrobe_t;

  function automatic logic [15:0] eeDefault(int idx);
    logic [7:0] b;
    b = 8'(idx);
    return {b ^ 8'hA0, b};
  endfunction

  function automatic logic [15:0] phyDefault(int idx, logic [3:0] linkMode);
    if (idx == 1) return 16'h782D;
    if (idx == 17) return {linkMode, 12'h000};
    return 16'h0000;
  endfunction

endpackage

// File: rtl/mgmt_access_ctrl.sv
module mgmt_access_ctrl
  import mgmt_access_pkg::*;
#(
  parameter int LAT_EE     = 400,
  parameter int LAT_PHY_RD = 5,
  parameter int LAT_PHY_WR = 25
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrEn,
  input  logic [7:0]  cmdCode,
  output mgmtStrobe_t strobe,
  output logic        busy
);

  localparam int MAX_LAT_A = (LAT_EE > LAT_PHY_RD) ? LAT_EE : LAT_PHY_RD;
  localparam int MAX_LAT   = (MAX_LAT_A > LAT_PHY_WR) ? MAX_LAT_A : LAT_PHY_WR;
  localparam int CNT_W     = $clog2(MAX_LAT + 1);
  localparam logic [CNT_W-1:0] LOAD_EE = CNT_W'(LAT_EE - 1);
  localparam logic [CNT_W-1:0] LOAD_PR = CNT_W'(LAT_PHY_RD - 1);
  localparam logic [CNT_W-1:0] LOAD_PW = CNT_W'(LAT_PHY_WR - 1);

  logic             validCode;
  logic             decPhy;
  logic             decWrite;
  logic [CNT_W-1:0] decLoad;
  logic [CNT_W-1:0] remain;
  logic             opPhy;
  logic             opWrite;
  logic             accept;

  always_comb begin
    validCode = 1'b1;
    decPhy    = 1'b0;
    decWrite  = 1'b0;
    decLoad   = LOAD_EE;
    case (cmdCode)
      CMD_EE_RD:  ;
      CMD_EE_WR:  decWrite = 1'b1;
      CMD_PHY_RD: begin decPhy = 1'b1; decLoad = LOAD_PR; end
      CMD_PHY_WR: begin decPhy = 1'b1; decWrite = 1'b1; decLoad = LOAD_PW; end
      default:    validCode = 1'b0;
    endcase
  end

  assign accept = cmdWrEn && validCode && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      remain  <= '0;
      opPhy   <= 1'b0;
      opWrite <= 1'b0;
    end else if (accept) begin
      busy    <= 1'b1;
      remain  <= decLoad;
      opPhy   <= decPhy;
      opWrite <= decWrite;
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

  always_comb begin
    strobe.capture = accept;
    strobe.finish  = busy && (remain == '0);
    strobe.toPhy   = accept ? decPhy : opPhy;
    strobe.isWrite = accept ? decWrite : opWrite;
  end

endmodule

// File: rtl/mgmt_access_dpath.sv
module mgmt_access_dpath
  import mgmt_access_pkg::*;
#(
  parameter int         EE_WORDS  = 64,
  parameter int         PHY_REGS  = 32,
  parameter logic [3:0] LINK_MODE = 4'h8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic [1:0]  hostSel,
  input  logic [7:0]  hostWrData,
  input  mgmtStrobe_t strobe,
  output logic [7:0]  addrQ,
  output logic [7:0]  loQ,
  output logic [7:0]  hiQ,
  output logic [7:0]  cmdQ
);

  localparam int EE_AW = $clog2(EE_WORDS);
  localparam int PHY_AW = $clog2(PHY_REGS);
  localparam int OP_AW = (EE_AW > PHY_AW) ? EE_AW : PHY_AW;

  logic [15:0]       eeMem  [EE_WORDS];
  logic [15:0]       phyMem [PHY_REGS];
  logic [OP_AW-1:0]  opAddr;
  logic [15:0]       opData;
  logic [EE_AW-1:0]  eeIdx;
  logic [PHY_AW-1:0] phyIdx;
  logic [15:0]       rdWord;
  logic              phyResetReq;

  assign eeIdx       = opAddr[EE_AW-1:0];
  assign phyIdx      = opAddr[PHY_AW-1:0];
  assign rdWord      = strobe.toPhy ? phyMem[phyIdx] : eeMem[eeIdx];
  assign phyResetReq = (phyIdx == '0) && (opData == PHY_RESET_WORD);

  // Host-visible registers and operation capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      loQ    <= '0;
      hiQ    <= '0;
      cmdQ   <= '0;
      opAddr <= '0;
      opData <= '0;
    end else begin
      if (hostWrEn) begin
        case (hostSel)
          SEL_ADDR: addrQ <= hostWrData;
          SEL_LO:   loQ   <= hostWrData;
          SEL_HI:   hiQ   <= hostWrData;
          default:  cmdQ  <= hostWrData;
        endcase
      end
      if (strobe.capture) begin
        opAddr <= addrQ[OP_AW-1:0];
        opData <= {hiQ, loQ};
      end
      if (strobe.finish && !strobe.isWrite) begin
        loQ <= rdWord[7:0];
        hiQ <= rdWord[15:8];
      end
    end
  end

  // EEPROM word store
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < EE_WORDS; i++) eeMem[i] <= eeDefault(i);
    end else if (strobe.finish && strobe.isWrite && !strobe.toPhy) begin
      eeMem[eeIdx] <= opData;
    end
  end

  // PHY register store, one process per register
  for (genvar g = 0; g < PHY_REGS; g++) begin : g_phyReg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        phyMem[g] <= phyDefault(g, LINK_MODE);
      end else if (strobe.finish && strobe.isWrite && strobe.toPhy) begin
        if (phyResetReq)                   phyMem[g] <= phyDefault(g, LINK_MODE);
        else if (phyIdx == PHY_AW'(g))     phyMem[g] <= opData;
      end
    end
  end

endmodule

// File: rtl/mgmt_access_engine.sv
module mgmt_access_engine
  import mgmt_access_pkg::*;
#(
  parameter int         LAT_EE     = 400,
  parameter int         LAT_PHY_RD = 5,
  parameter int         LAT_PHY_WR = 25,
  parameter int         EE_WORDS   = 64,
  parameter int         PHY_REGS   = 32,
  parameter logic [3:0] LINK_MODE  = 4'h8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWrEn,
  input  logic [1:0] hostSel,
  input  logic [7:0] hostWrData,
  input  logic [1:0] hostRdSel,
  output logic [7:0] hostRdData,
  output logic       busy
);

  mgmtStrobe_t strobe;
  logic [7:0]  addrQ;
  logic [7:0]  loQ;
  logic [7:0]  hiQ;
  logic [7:0]  cmdQ;
  logic        cmdWrEn;

  assign cmdWrEn = hostWrEn && (hostSel == SEL_CMD);

  mgmt_access_ctrl #(
    .LAT_EE(LAT_EE), .LAT_PHY_RD(LAT_PHY_RD), .LAT_PHY_WR(LAT_PHY_WR)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdCode(hostWrData),
    .strobe(strobe), .busy(busy)
  );

  mgmt_access_dpath #(
    .EE_WORDS(EE_WORDS), .PHY_REGS(PHY_REGS), .LINK_MODE(LINK_MODE)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .hostWrData(hostWrData), .strobe(strobe),
    .addrQ(addrQ), .loQ(loQ), .hiQ(hiQ), .cmdQ(cmdQ)
  );

  always_comb begin
    case (hostRdSel)
      SEL_ADDR: hostRdData = addrQ;
      SEL_LO:   hostRdData = loQ;
      SEL_HI:   hostRdData = hiQ;
      default:  hostRdData = cmdQ;
    endcase
  end

endmodule

// File: rtl/mgmt_access_chk.sv
module mgmt_access_chk
  import mgmt_access_pkg::*;
#(
  parameter int LAT_EE     = 400,
  parameter int LAT_PHY_RD = 5,
  parameter int LAT_PHY_WR = 25
) (
  input logic       clk,
  input logic       rstN,
  input logic       hostWrEn,
  input logic [1:0] hostSel,
  input logic [7:0] hostWrData,
  input logic       busy,
  input logic [7:0] loQ,
  input logic [7:0] cmdQ
);

  localparam int MAX_A   = (LAT_EE > LAT_PHY_RD) ? LAT_EE : LAT_PHY_RD;
  localparam int MAX_LAT = (MAX_A > LAT_PHY_WR) ? MAX_A : LAT_PHY_WR;
  localparam int RUN_W   = $clog2(MAX_LAT + 2);

  logic [RUN_W-1:0] busyRun;
  logic             cmdWr;
  logic             knownCode;

  assign cmdWr     = hostWrEn && (hostSel == SEL_CMD);
  assign knownCode = (hostWrData == CMD_EE_RD) || (hostWrData == CMD_EE_WR) ||
                     (hostWrData == CMD_PHY_RD) || (hostWrData == CMD_PHY_WR);

  always_ff @(posedge clk) begin
    if (!rstN)                            busyRun <= '0;
    else if (!busy)                       busyRun <= '0;
    else if (busyRun != RUN_W'(MAX_LAT + 1)) busyRun <= busyRun + 1'b1;
  end

  AST_ISSUE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && knownCode && !busy) |=> busy);                          // R3

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= RUN_W'(MAX_LAT));                                      // R4

  AST_IDLE_DATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(hostWrEn && hostSel == SEL_LO)) |=> $stable(loQ));    // R5

  AST_BAD_CODE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !knownCode && !busy) |=> !busy);                        // R8

  AST_ZERO_CMD_STORED: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && hostWrData == 8'h00) |=> (cmdQ == 8'h00));              // R9

endmodule

bind mgmt_access_engine mgmt_access_chk #(
  .LAT_EE(LAT_EE), .LAT_PHY_RD(LAT_PHY_RD), .LAT_PHY_WR(LAT_PHY_WR)
) i_chk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostSel(hostSel),
  .hostWrData(hostWrData), .busy(busy), .loQ(loQ), .cmdQ(cmdQ)
);

// File: tb/test_mgmt_access_engine.sv
module test_mgmt_access_engine;

  localparam int EE_LAT  = 400;
  localparam int PRD_LAT = 5;
  localparam int PWR_LAT = 25;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWrEn = 1'b0;
  logic [1:0] hostSel = 2'd0;
  logic [7:0] hostWrData = 8'h00;
  logic [1:0] hostRdSel = 2'd0;
  logic [7:0] hostRdData;
  logic       busy;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    string       tag;
    int          lat;
    bit          isRead;
    logic [15:0] word;
  } exp_t;
  exp_t sbQ[$];

  always #5 clk = ~clk;

  mgmt_access_engine #(
    .LAT_EE(EE_LAT), .LAT_PHY_RD(PRD_LAT), .LAT_PHY_WR(PWR_LAT)
  ) i_mgmt_access_engine (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .hostWrData(hostWrData), .hostRdSel(hostRdSel), .hostRdData(hostRdData),
    .busy(busy)
  );

  function automatic logic [15:0] eeExp(int a);
    logic [7:0] b;
    b = 8'(a);
    return {8'hA0 ^ b, b};
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrReg(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostSel = sel; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [1:0] sel, output logic [7:0] d);
    hostRdSel = sel;
    #1;
    d = hostRdData;
  endtask

  task automatic access(string tag, logic [7:0] code, logic [7:0] addr,
                        logic [15:0] wdata, int lat, bit isRead, logic [15:0] word);
    exp_t e;
    wrReg(2'd0, addr);
    if (!isRead) begin
      wrReg(2'd1, wdata[7:0]);
      wrReg(2'd2, wdata[15:8]);
    end
    e.tag = tag; e.lat = lat; e.isRead = isRead; e.word = word;
    sbQ.push_back(e);
    wrReg(2'd3, code);
    wait (sbQ.size() == 0);
    @(negedge clk);
    wrReg(2'd3, 8'h00);
  endtask

  // Monitor: count busy cycles, compare on each completion
  initial begin
    int run = 0;
    bit prev = 1'b0;
    forever begin
      @(negedge clk);
      if (busy) run++;
      else if (prev) begin
        if (sbQ.size() == 0) begin
          check("R8 unexpected completion", 16'(run), 16'hFFFF);
        end else begin
          exp_t e;
          logic [7:0] lo, hi;
          e = sbQ.pop_front();
          check({e.tag, " R4 latency"}, 16'(run), 16'(e.lat));
          if (e.isRead) begin
            hostRdSel = 2'd1; #1 lo = hostRdData;
            hostRdSel = 2'd2; #1 hi = hostRdData;
            check({e.tag, " R5 word"}, {hi, lo}, e.word);
          end
        end
        run = 0;
      end
      prev = busy;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    exp_t e;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", 16'(busy), 16'h0);
    for (int s = 0; s < 4; s++) begin
      rdReg(2'(s), r);
      check("R1 register", 16'(r), 16'h0);
    end

    // R2 register writes and readback
    wrReg(2'd0, 8'h5C); rdReg(2'd0, r); check("R2 addr", 16'(r), 16'h5C);
    wrReg(2'd1, 8'h3E); rdReg(2'd1, r); check("R2 lo", 16'(r), 16'h3E);
    wrReg(2'd2, 8'h91); rdReg(2'd2, r); check("R2 hi", 16'(r), 16'h91);

    // R3 R12 EEPROM default words
    access("R3 R12 ee rd 3", 8'h04, 8'h03, 16'h0, EE_LAT, 1'b1, eeExp(3));
    access("R12 ee rd 63", 8'h04, 8'h3F, 16'h0, EE_LAT, 1'b1, eeExp(63));

    // R9 zero command after completion
    rdReg(2'd3, r); check("R9 cmd cleared", 16'(r), 16'h00);
    check("R9 idle after zero", 16'(busy), 16'h0);

    // R5 data held while idle
    repeat (4) @(negedge clk);
    rdReg(2'd1, r); check("R5 lo held", 16'(r), 16'(eeExp(63) & 16'hFF));

    // R6 EEPROM write then read
    access("R6 ee wr 10", 8'h12, 8'h0A, 16'hBEEF, EE_LAT, 1'b0, 16'h0);
    access("R6 ee rd 10", 8'h04, 8'h0A, 16'h0, EE_LAT, 1'b1, 16'hBEEF);

    // R10 PHY defaults
    access("R10 phy rd 1", 8'h0C, 8'h41, 16'h0, PRD_LAT, 1'b1, 16'h782D);
    access("R10 phy rd 17", 8'h0C, 8'h51, 16'h0, PRD_LAT, 1'b1, 16'h8000);

    // R7 addressing with and without the select flag
    access("R7 phy wr 5", 8'h0A, 8'h45, 16'h1357, PWR_LAT, 1'b0, 16'h0);
    access("R7 phy rd 0x45", 8'h0C, 8'h45, 16'h0, PRD_LAT, 1'b1, 16'h1357);
    access("R7 phy rd 0x05", 8'h0C, 8'h05, 16'h0, PRD_LAT, 1'b1, 16'h1357);
    access("R7 ee rd 0x45", 8'h04, 8'h45, 16'h0, EE_LAT, 1'b1, eeExp(5));

    // R8 unknown code
    wrReg(2'd3, 8'h33);
    check("R8 bad code busy", 16'(busy), 16'h0);
    repeat (3) @(negedge clk);
    check("R8 bad code still idle", 16'(busy), 16'h0);
    wrReg(2'd3, 8'h00);
    access("R8 ee word untouched", 8'h04, 8'h03, 16'h0, EE_LAT, 1'b1, eeExp(3));

    // R8 command while busy is ignored
    wrReg(2'd0, 8'h47);
    wrReg(2'd1, 8'hFF);
    wrReg(2'd2, 8'hFF);
    e.tag = "R8 busy ee rd 7"; e.lat = EE_LAT; e.isRead = 1'b1; e.word = eeExp(7);
    sbQ.push_back(e);
    wrReg(2'd3, 8'h04);
    wrReg(2'd3, 8'h0A);
    wait (sbQ.size() == 0);
    @(negedge clk);
    wrReg(2'd3, 8'h00);
    access("R8 phy 7 untouched", 8'h0C, 8'h47, 16'h0, PRD_LAT, 1'b1, 16'h0000);

    // R11 PHY reset
    access("R11 phy wr 17", 8'h0A, 8'h51, 16'h1234, PWR_LAT, 1'b0, 16'h0);
    access("R11 phy rd 17 dirty", 8'h0C, 8'h51, 16'h0, PRD_LAT, 1'b1, 16'h1234);
    access("R11 phy reset", 8'h0A, 8'h40, 16'h8000, PWR_LAT, 1'b0, 16'h0);
    access("R11 phy rd 0", 8'h0C, 8'h40, 16'h0, PRD_LAT, 1'b1, 16'h0000);
    access("R11 phy rd 17 default", 8'h0C, 8'h51, 16'h0, PRD_LAT, 1'b1, 16'h8000);
    access("R11 phy rd 5 cleared", 8'h0C, 8'h45, 16'h0, PRD_LAT, 1'b1, 16'h0000);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule